// File: doc/BRIEF.md
# Flash Word-Program Command Controller

This block models the command front end and the internal write sequencer of a parallel NOR flash, limited to programming single words. A host drives a synchronous bus made of chip enable, write enable, output enable, a word address and a 16-bit data word. Writes carry command codes in the low byte, or the address and data of a program operation. Reads return either the contents of a small internal word array, the 8-bit status register or an identifier word, depending on the read mode that the last accepted command selected.

A program operation has two writes: a setup command, then a write that carries the target address and data. The controller checks the supply-valid input and the lock bit of the target block. It then either reports an error in the status register right away or enters a busy period of a fixed number of clock cycles. At the end of that period the word is merged into the array. Error flags are sticky until the host clears them. While the sequencer is busy, only the mode-changing read commands are honoured.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array mode, every array word reads FFFFh, and the status register reads 0080h (ready, no error flags).
- R2: A bus write takes place in each clock cycle with ce_n and we_n both low. A write of 40h or 10h while ready starts a program setup, and the next write supplies the target address and data. From the setup on, a read at any address returns the status register zero-extended to 16 bits.
- R3: A completed program stores the bitwise AND of the old word and the written data, so bits only ever go from 1 to 0.
- R4: Status bit 7 reads 0 for exactly PROG_CYCLES clock edges after the data write of an accepted program, and 1 from then on.
- R5: A program aimed at a locked block (block index = upper address bits above BLK_W; by default only block 2, words 8 to 11, is locked) sets status bits 4 and 1, leaves the array unchanged and does not enter the busy period.
- R6: A program whose data write arrives with vpp_ok low sets status bit 3 only, leaves the array unchanged and does not enter the busy period. This check takes priority over the lock check.
- R7: While busy, only 70h, FFh and 90h take effect (they change the read mode). All other writes, including 40h, 10h and 50h, are ignored. An array-mode read while busy returns FFFFh.
- R8: Status bits 4, 3 and 1 stay set until a 50h write while ready clears them. That write leaves the read mode unchanged.
- R9: While ready, 70h selects status mode, FFh selects array mode and 90h selects identifier mode, in which every address reads ID_WORD (default 00A7h). Any other code is ignored.
- R10: rdata is 0000h whenever ce_n or oe_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data; commands use the low byte |
| vpp_ok | input | 1 | Programming supply within its valid range |
| rdata | output | 16 | Read data: array word, status or identifier |

## Verification
The embedded properties watch, on every cycle, that errors never clear without an accepted clear command, that no setup can begin during the busy period, that the busy counter stays in range, that a supply error only appears after a write made with the supply low, that a commit never reaches a locked block, and that a committed word never gains a set bit. The exact busy length, the status values after each error path, the ignoring of commands while busy, the AND merge result and the identifier and disabled-output reads can only be shown by the bench's scenarios.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        ST_READY,
        ST_SETUP,
        ST_BUSY
    } wsm_state_e;

    typedef enum logic [1:0] {
        MD_ARRAY,
        MD_STATUS,
        MD_IDENT
    } rd_mode_e;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_PROG,
        CK_CLEAR,
        CK_RSTAT,
        CK_RARRAY,
        CK_RIDENT
    } cmd_kind_e;

    localparam int SR_READY    = 7;
    localparam int SR_PGM_ERR  = 4;
    localparam int SR_VPP_ERR  = 3;
    localparam int SR_LOCK_ERR = 1;
    localparam logic [7:0] ERR_MASK = 8'h1A;

    localparam logic [7:0] OP_PROG_A = 8'h40;
    localparam logic [7:0] OP_PROG_B = 8'h10;
    localparam logic [7:0] OP_CLEAR  = 8'h50;
    localparam logic [7:0] OP_RSTAT  = 8'h70;
    localparam logic [7:0] OP_RARRAY = 8'hFF;
    localparam logic [7:0] OP_RIDENT = 8'h90;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_kind_e  kind,
    output logic       busy_ok
);

    always_comb begin
        case (code)
            OP_PROG_A, OP_PROG_B: kind = CK_PROG;
            OP_CLEAR:             kind = CK_CLEAR;
            OP_RSTAT:             kind = CK_RSTAT;
            OP_RARRAY:            kind = CK_RARRAY;
            OP_RIDENT:            kind = CK_RIDENT;
            default:              kind = CK_NONE;
        endcase
        busy_ok = (kind == CK_RSTAT) || (kind == CK_RARRAY) || (kind == CK_RIDENT);
    end

endmodule

// File: rtl/flash_word_store.sv
module flash_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 2,
    parameter logic [(1 << (ADDR_W - BLK_W)) - 1:0] LOCK_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_locked
);

    localparam int WORDS  = 1 << ADDR_W;
    localparam int BLOCKS = 1 << (ADDR_W - BLK_W);

    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] mem_q [WORDS];
    logic [BLOCKS-1:0] lock_d, lock_q;

    always_comb begin
        mem_d  = mem_q;
        lock_d = lock_q;
        if (wr_en) begin
            mem_d[wr_addr] = mem_q[wr_addr] & wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q  <= '{default: '1};
            lock_q <= LOCK_INIT;
        end else begin
            mem_q  <= mem_d;
            lock_q <= lock_d;
        end
    end

    assign rd_data    = mem_q[rd_addr];
    assign chk_locked = lock_q[chk_addr[ADDR_W-1:BLK_W]];

    // R3
    no_set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem_q[$past(wr_addr)] & ~$past(wr_data)) == '0));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int BLK_W       = 2,
    parameter int PROG_CYCLES = 8,
    parameter logic [(1 << (ADDR_W - BLK_W)) - 1:0] LOCK_INIT = 4'b0100,
    parameter logic [15:0] ID_WORD = 16'h00A7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              vpp_ok,
    output logic [15:0]       rdata
);

    localparam int DATA_W = 16;
    localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        wsm_state_e        st;
        rd_mode_e          mode;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        err;
        logic [ADDR_W-1:0] pa;
        logic [DATA_W-1:0] pd;
    } ctrl_t;

    ctrl_t             ctl_d, ctl_q;
    cmd_kind_e         kind;
    logic              busy_ok;
    logic              wr_stb;
    logic              commit;
    logic              locked;
    logic [ADDR_W-1:0] chk_addr;
    logic [DATA_W-1:0] arr_word;
    logic [7:0]        status;

    assign wr_stb   = !ce_n && !we_n;
    assign chk_addr = (ctl_q.st == ST_SETUP) ? addr : ctl_q.pa;

    flash_cmd_decode u_dec (
        .code    (wdata[7:0]),
        .kind    (kind),
        .busy_ok (busy_ok)
    );

    flash_word_store #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BLK_W     (BLK_W),
        .LOCK_INIT (LOCK_INIT)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (commit),
        .wr_addr    (ctl_q.pa),
        .wr_data    (ctl_q.pd),
        .rd_addr    (addr),
        .rd_data    (arr_word),
        .chk_addr   (chk_addr),
        .chk_locked (locked)
    );

    always_comb begin
        ctl_d  = ctl_q;
        commit = 1'b0;
        case (ctl_q.st)
            ST_READY: begin
                if (wr_stb) begin
                    case (kind)
                        CK_PROG: begin
                            ctl_d.st   = ST_SETUP;
                            ctl_d.mode = MD_STATUS;
                        end
                        CK_CLEAR:  ctl_d.err  = ctl_q.err & ~ERR_MASK;
                        CK_RSTAT:  ctl_d.mode = MD_STATUS;
                        CK_RARRAY: ctl_d.mode = MD_ARRAY;
                        CK_RIDENT: ctl_d.mode = MD_IDENT;
                        default: ;
                    endcase
                end
            end
            ST_SETUP: begin
                if (wr_stb) begin
                    if (!vpp_ok) begin
                        ctl_d.err[SR_VPP_ERR] = 1'b1;
                        ctl_d.st              = ST_READY;
                    end else if (locked) begin
                        ctl_d.err[SR_PGM_ERR]  = 1'b1;
                        ctl_d.err[SR_LOCK_ERR] = 1'b1;
                        ctl_d.st               = ST_READY;
                    end else begin
                        ctl_d.st  = ST_BUSY;
                        ctl_d.cnt = CNT_W'(PROG_CYCLES - 1);
                        ctl_d.pa  = addr;
                        ctl_d.pd  = wdata;
                    end
                end
            end
            ST_BUSY: begin
                if (wr_stb && busy_ok) begin
                    case (kind)
                        CK_RSTAT:  ctl_d.mode = MD_STATUS;
                        CK_RARRAY: ctl_d.mode = MD_ARRAY;
                        default:   ctl_d.mode = MD_IDENT;
                    endcase
                end
                if (ctl_q.cnt == '0) begin
                    commit   = 1'b1;
                    ctl_d.st = ST_READY;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d.st = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_READY, mode: MD_ARRAY, cnt: '0, err: '0, pa: '0, pd: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign status = {ctl_q.st != ST_BUSY, ctl_q.err[6:0]};

    always_comb begin
        if (ce_n || oe_n) begin
            rdata = '0;
        end else begin
            case (ctl_q.mode)
                MD_STATUS: rdata = DATA_W'(status);
                MD_IDENT:  rdata = ID_WORD;
                default:   rdata = (ctl_q.st == ST_BUSY) ? '1 : arr_word;
            endcase
        end
    end

    // R7
    no_setup_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_BUSY) |=> (ctl_q.st != ST_SETUP));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_BUSY) |-> (ctl_q.cnt < CNT_W'(PROG_CYCLES)));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && kind == CK_CLEAR && ctl_q.st == ST_READY)
        |=> (($past(ctl_q.err) & ~ctl_q.err) == '0));

    // R6
    vpp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.err[SR_VPP_ERR]) |-> !$past(vpp_ok));

    // R5
    no_locked_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !locked);

endmodule

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;

    localparam int P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        vpp_ok = 1'b1;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.PROG_CYCLES(P)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .vpp_ok(vpp_ok), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #1 v = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_ready();
        logic [15:0] v;
        for (int i = 0; i < 100; i++) begin
            rd(4'd0, v);
            if (v[7]) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(4'd0, v);   check("R1 array after reset", v, 16'hFFFF);
        rd(4'd15, v);  check("R1 array top word", v, 16'hFFFF);
        wr(4'd0, 16'h0070);
        rd(4'd0, v);   check("R1 status after reset", v, 16'h0080);
        wr(4'd0, 16'h00FF);
    endtask

    task automatic t_program();
        logic [15:0] v;
        wr(4'd0, 16'h0040);
        rd(4'd7, v);   check("R2 status mode after setup", v, 16'h0080);
        wr(4'd3, 16'hF0F3);
        rd(4'd12, v);  check("R4 busy right after data", v, 16'h0000);
        repeat (P - 1) @(negedge clk);
        rd(4'd0, v);   check("R4 busy at last busy cycle", v, 16'h0000);
        @(negedge clk);
        rd(4'd0, v);   check("R4 ready after PROG_CYCLES", v, 16'h0080);
        wr(4'd0, 16'h00FF);
        rd(4'd3, v);   check("R2 programmed word", v, 16'hF0F3);
        wr(4'd0, 16'h0010);
        wr(4'd3, 16'h0F0F);
        wait_ready();
        wr(4'd0, 16'h00FF);
        rd(4'd3, v);   check("R3 AND merge", v, 16'h0003);
    endtask

    task automatic t_locked();
        logic [15:0] v;
        wr(4'd0, 16'h0040);
        wr(4'd9, 16'h0000);
        rd(4'd0, v);   check("R5 lock error no busy", v, 16'h0092);
        wr(4'd0, 16'h00FF);
        rd(4'd9, v);   check("R5 locked word unchanged", v, 16'hFFFF);
        wr(4'd0, 16'h0040);
        wr(4'd0, 16'h1111);
        wait_ready();
        rd(4'd0, v);   check("R8 errors sticky over program", v, 16'h0092);
        wr(4'd0, 16'h0050);
        rd(4'd4, v);   check("R8 clear keeps status mode", v, 16'h0080);
        wr(4'd0, 16'h00FF);
        rd(4'd0, v);   check("R2 program after lock error", v, 16'h1111);
    endtask

    task automatic t_vpp();
        logic [15:0] v;
        vpp_ok = 1'b0;
        wr(4'd0, 16'h0040);
        wr(4'd8, 16'h0000);
        rd(4'd0, v);   check("R6 vpp error wins over lock", v, 16'h0088);
        wr(4'd0, 16'h0010);
        wr(4'd1, 16'h0000);
        rd(4'd0, v);   check("R6 vpp error no busy", v, 16'h0088);
        wr(4'd0, 16'h00FF);
        rd(4'd1, v);   check("R6 word unchanged", v, 16'hFFFF);
        vpp_ok = 1'b1;
    endtask

    task automatic t_busy();
        logic [15:0] v;
        wr(4'd0, 16'h0040);
        wr(4'd5, 16'h1234);
        wr(4'd0, 16'h0050);
        wr(4'd0, 16'h00FF);
        rd(4'd5, v);   check("R7 array read while busy", v, 16'hFFFF);
        wr(4'd0, 16'h0070);
        rd(4'd0, v);   check("R7 clear ignored while busy", v, 16'h0008);
        wr(4'd0, 16'h0040);
        wr(4'd6, 16'h0000);
        wait_ready();
        rd(4'd0, v);   check("R8 error kept after busy", v, 16'h0088);
        wr(4'd0, 16'h00FF);
        rd(4'd5, v);   check("R7 program completed", v, 16'h1234);
        rd(4'd6, v);   check("R7 setup ignored while busy", v, 16'hFFFF);
        wr(4'd0, 16'h0050);
    endtask

    task automatic t_modes();
        logic [15:0] v;
        wr(4'd0, 16'h0090);
        rd(4'd2, v);   check("R9 identifier mode", v, 16'h00A7);
        wr(4'd0, 16'h0021);
        rd(4'd11, v);  check("R9 unknown code ignored", v, 16'h00A7);
        wr(4'd0, 16'h0070);
        rd(4'd2, v);   check("R9 status mode", v, 16'h0080);
        ce_n = 1'b1; oe_n = 1'b0;
        #1 check("R10 chip disabled", rdata, 16'h0000);
        oe_n = 1'b1; ce_n = 1'b0;
        #1 check("R10 output disabled", rdata, 16'h0000);
        ce_n = 1'b1;
        wr(4'd0, 16'h00FF);
        rd(4'd3, v);   check("R9 array mode", v, 16'h0003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_locked();
        t_vpp();
        t_busy();
        t_modes();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule